// File: doc/BRIEF.md
# Retransmit Prefix Buffer

This block sits between a packet source and a half-duplex transmitter. Each word it carries is a byte plus an error flag, with a last flag that closes the frame. Both sides use valid/ready/last handshakes. While a frame is still inside its early-collision window, the buffer keeps every word of it from the first word on. When the transmitter sees an early collision, it pulses `replay_i` and gets the frame again from its first word.

Once the window has passed, the transmitter pulses `commit_i`. This pulse is also used when the transmitter gives up or aborts a frame and drains the rest of it. After the commit, the retained prefix is released, replay requests are ignored, and the buffer behaves as a plain FIFO of `DEPTH` words. When the final word of a committed frame leaves the output, the next word becomes the new rewind point. The default depth of 57 words is one 64-byte slot minus the 8-byte preamble, plus one.

Top module: `replay_buffer`

## Requirements
- R1: Words leave in the order they entered. Byte, error flag and last flag come out unchanged on `out_data_o`, `out_err_o` and `out_last_o`.
- R2: Before a commit, every word of the current frame counts toward capacity from the frame's first word, including words already read. `in_ready_o` goes low once `DEPTH` such words are held, and stays low even while those words are read out.
- R3: A `replay_i` pulse before the commit makes the first word of the current frame the next word presented. The whole frame then follows again in order.
- R4: After `commit_i`, words already read are freed. Input resumes, so a frame longer than `DEPTH` flows through completely.
- R5: A `replay_i` pulse after the commit of the current frame has no effect on the output sequence.
- R6: When `replay_i` and `commit_i` arrive in the same cycle, the commit wins and no rewind happens.
- R7: Once the last word of a committed frame is accepted at the output, the following word is the rewind point for later `replay_i` pulses. Accepting last together with `commit_i` in the same cycle has the same effect.
- R8: The active-low asynchronous reset `rst_ni` empties the buffer, holds `out_valid_o` low, leaves `in_ready_o` high and clears the committed state.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the presented word stays unchanged, unless a replay that takes effect occurs.
- R10: A replay that takes effect in the same cycle as an output handshake discards that handshake. The word is presented again later as part of the replayed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input byte |
| in_err_i | input | 1 | Error flag attached to the input byte |
| in_last_i | input | 1 | Marks the final word of a frame |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Buffer can accept a word |
| out_data_o | output | 8 | Output byte |
| out_err_o | output | 1 | Error flag of the output byte |
| out_last_o | output | 1 | Output word ends its frame |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the output word |
| replay_i | input | 1 | Single-cycle request to rewind to the frame start |
| commit_i | input | 1 | Single-cycle pulse that releases the retained prefix |

## Verification
A directed sequence first pushes a 70-word frame against a stalled consumer. This shows the input stopping at 57 words, and staying stopped after some words are read. It then checks that a replay brings back word zero, and that a commit lets the remaining 13 words through. A short second frame separates the rewind point of a new frame from the old one. It also covers commit and replay arriving in the same cycle, and a replay arriving after the commit. A random phase then runs frame lengths of 1, 2, 56, 57, 58 and up to 200 words, with random backpressure, replays at random points and commits at random depths. A scoreboard restarts its expected index at the frame start on each replay that takes effect, so any wrong rewind target, lost word or early release shows up as a mismatch.

// File: rtl/replay_buffer_pkg.sv
package replay_buffer_pkg;

  // side flags carried next to each byte
  typedef struct packed {
    logic last;
    logic err;
  } rb_flags_t;

  function automatic int unsigned rb_idx_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/replay_buffer_mem.sv
module replay_buffer_mem #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned DEPTH  = 57,
  localparam int unsigned IDX_W = replay_buffer_pkg::rb_idx_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == IDX_W'(e))) mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/replay_buffer_ctrl.sv
module replay_buffer_ctrl #(
  parameter int unsigned DEPTH = 57,
  localparam int unsigned IDX_W = replay_buffer_pkg::rb_idx_w(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_fire_i,
  input  logic             rd_fire_i,
  input  logic             rd_last_i,
  input  logic             replay_i,
  input  logic             commit_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] held_o,
  output logic [CNT_W-1:0] ahead_o,
  output logic             committed_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] wr_q, rd_q, st_q, wr_d, rd_d, st_d, rd_adv;
  logic [CNT_W-1:0] held_q, ahead_q, held_d, ahead_d, ahead_adv, held_add;
  logic             committed_q, committed_d;
  logic             release_w, rewind_w;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  assign release_w = committed_q | commit_i;
  assign rewind_w  = replay_i & ~release_w;
  assign rd_adv    = rd_fire_i ? bump(rd_q) : rd_q;
  assign ahead_adv = ahead_q + CNT_W'(rd_fire_i);
  assign held_add  = held_q + CNT_W'(wr_fire_i);

  always_comb begin
    wr_d    = wr_fire_i ? bump(wr_q) : wr_q;
    st_d    = st_q;
    rd_d    = rd_adv;
    ahead_d = ahead_adv;
    held_d  = held_add;
    if (release_w) begin
      // frame start follows the read side: consumed words are freed
      st_d    = rd_adv;
      ahead_d = '0;
      held_d  = held_add - ahead_adv;
    end else if (rewind_w) begin
      rd_d    = st_q;
      ahead_d = '0;
    end
    committed_d = committed_q;
    if (release_w && rd_fire_i && rd_last_i) committed_d = 1'b0;
    else if (commit_i)                       committed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= '0;
      rd_q        <= '0;
      st_q        <= '0;
      held_q      <= '0;
      ahead_q     <= '0;
      committed_q <= 1'b0;
    end else begin
      wr_q        <= wr_d;
      rd_q        <= rd_d;
      st_q        <= st_d;
      held_q      <= held_d;
      ahead_q     <= ahead_d;
      committed_q <= committed_d;
    end
  end

  assign wr_idx_o    = wr_q;
  assign rd_idx_o    = rd_q;
  assign held_o      = held_q;
  assign ahead_o     = ahead_q;
  assign committed_o = committed_q;

  // R2
  ring_consistent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q == st_q) |-> (held_q == '0 || held_q == CNT_W'(DEPTH)));

  // R3
  replay_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_i && !committed_q && !commit_i) |=> (rd_q == $past(st_q) && ahead_q == '0));

  // R4
  commit_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    committed_q |-> (st_q == rd_q && ahead_q == '0));

  // R5
  replay_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_i && committed_q && !rd_fire_i) |=> (rd_q == $past(rd_q)));

  // R6
  commit_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_i && commit_i && !committed_q && !rd_fire_i) |=> (rd_q == $past(rd_q) && committed_q));

  // R7
  frame_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_q && rd_fire_i && rd_last_i) |=> (!committed_q && st_q == rd_q));

endmodule

// File: rtl/replay_buffer.sv
module replay_buffer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 57
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_err_i,
  input  logic              in_last_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_err_o,
  output logic              out_last_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  input  logic              replay_i,
  input  logic              commit_i
);
  import replay_buffer_pkg::*;

  localparam int unsigned IDX_W  = rb_idx_w(DEPTH);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned WORD_W = DATA_W + $bits(rb_flags_t);

  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [CNT_W-1:0]  held, ahead;
  logic              committed, wr_fire, rd_fire;
  logic [WORD_W-1:0] wr_word, rd_word;
  rb_flags_t         in_flags, out_flags;

  assign in_ready_o  = held < CNT_W'(DEPTH);
  assign out_valid_o = held != ahead;
  assign wr_fire     = in_valid_i & in_ready_o;
  assign rd_fire     = out_valid_o & out_ready_i;

  assign in_flags = '{last: in_last_i, err: in_err_i};
  assign wr_word  = {in_data_i, in_flags};
  assign {out_data_o, out_flags} = rd_word;
  assign out_err_o  = out_flags.err;
  assign out_last_o = out_flags.last;

  replay_buffer_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_idx),
    .wdata_i (wr_word),
    .raddr_i (rd_idx),
    .rdata_o (rd_word)
  );

  replay_buffer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_fire_i   (wr_fire),
    .rd_fire_i   (rd_fire),
    .rd_last_i   (out_last_o),
    .replay_i    (replay_i),
    .commit_i    (commit_i),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .held_o      (held),
    .ahead_o     (ahead),
    .committed_o (committed)
  );

  // R9
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !(replay_i && !committed && !commit_i))
      |=> (out_valid_o && $stable({out_data_o, out_err_o, out_last_o})));

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (held != '0));

endmodule

// File: tb/replay_buffer_bench.sv
module replay_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 57;
  localparam int NF = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic in_err_i = 1'b0, in_last_i = 1'b0, in_valid_i = 1'b0;
  logic in_ready_o, out_err_o, out_last_o, out_valid_o;
  logic [7:0] out_data_o;
  logic out_ready_i = 1'b0, replay_i = 1'b0, commit_i = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  replay_buffer #(.DATA_W(8), .DEPTH(DEPTH)) u_replay_buffer (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [9:0] sent_q[$];
  int lens[NF] = '{1, 2, 56, 57, 58, 120, 3, 64, 10, 200};

  function automatic logic [9:0] cur_word();
    return {out_data_o, out_err_o, out_last_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_frame(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_data_i  = 8'(base + i);
      in_err_i   = (i % 5) == 3;
      in_last_i  = (i == len - 1);
      while (!in_ready_o) @(negedge clk_i);
      sent_q.push_back({in_data_i, in_err_i, in_last_i});
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic pull(input int idx, input string req);
    out_ready_i = 1'b1;
    while (!out_valid_o) @(negedge clk_i);
    if (idx < sent_q.size()) check(cur_word() == sent_q[idx], req, cur_word(), sent_q[idx]);
    else check(1'b0, req, cur_word(), 10'h0);
    @(negedge clk_i);
    out_ready_i = 1'b0;
  endtask

  task automatic pulse(input bit r, input bit c);
    replay_i = r;
    commit_i = c;
    @(negedge clk_i);
    replay_i = 1'b0;
    commit_i = 1'b0;
  endtask

  task automatic drive_random();
    for (int f = 0; f < NF; f++) begin
      send_frame(lens[f], f * 16);
      repeat ($urandom % 4) @(negedge clk_i);
    end
  endtask

  // scoreboard monitor: model of the rewind point from the requirements
  task automatic monitor_random();
    int rd = 0, base = 0, rcnt = 0, done = 0, reps = 3, cat;
    bit com_m = 0;
    cat = 1 + $urandom % ((lens[0] < DEPTH) ? lens[0] : DEPTH);
    while (done < NF) begin
      bit rdy, hs, rep, com, rew;
      logic [9:0] w;
      @(negedge clk_i);
      rdy = ($urandom % 4) != 0;
      hs  = out_valid_o && rdy;
      rep = 0;
      com = 0;
      if (!com_m && reps > 0 && ($urandom % 16) == 0) rep = 1;
      if (com_m && ($urandom % 12) == 0) rep = 1;           // R5
      if (!com_m && hs && rcnt + 1 == cat) begin
        com = 1;
        if (($urandom % 3) == 0) rep = 1;                   // R6
      end
      out_ready_i = rdy;
      replay_i = rep;
      commit_i = com;
      w = cur_word();
      if (hs) begin
        if (rd < sent_q.size()) check(w == sent_q[rd], "R1/R3/R5/R6/R10 stream", w, sent_q[rd]);
        else check(1'b0, "R1 overrun", w, 10'h0);
      end
      rew = rep && !com_m && !com;                           // R10: handshake dropped on rewind
      if (com) com_m = 1;
      if (rew) begin
        rd = base;
        rcnt = 0;
        reps--;
      end else if (hs) begin
        rd++;
        rcnt++;
        if (w[0] && com_m) begin                             // R7
          base = rd;
          com_m = 0;
          rcnt = 0;
          reps = 3;
          done++;
          if (done < NF) cat = 1 + $urandom % ((lens[done] < DEPTH) ? lens[done] : DEPTH);
        end
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b0;
    replay_i = 1'b0;
    commit_i = 1'b0;
  endtask

  initial begin
    logic [9:0] w0;
    repeat (3) @(negedge clk_i);
    // R8
    check(!out_valid_o && in_ready_o, "R8 reset", {out_valid_o, in_ready_o}, 10'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!out_valid_o && in_ready_o, "R8 after reset", {out_valid_o, in_ready_o}, 10'b01);

    fork send_frame(70, 0); join_none
    repeat (80) @(negedge clk_i);
    check(sent_q.size() == DEPTH && !in_ready_o, "R2 stall at depth", 10'(sent_q.size()), 10'(DEPTH));
    w0 = cur_word();
    @(negedge clk_i);
    check(out_valid_o && cur_word() == w0, "R9 hold", cur_word(), w0);
    for (int i = 0; i < 10; i++) pull(i, "R1 in order");
    repeat (5) @(negedge clk_i);
    check(sent_q.size() == DEPTH && !in_ready_o, "R2 read words still retained", 10'(sent_q.size()), 10'(DEPTH));
    pulse(1, 0);
    check(out_valid_o && cur_word() == sent_q[0], "R3 rewind to first", cur_word(), sent_q[0]);
    for (int i = 0; i < DEPTH; i++) pull(i, "R3 replayed frame");
    check(!out_valid_o, "R3 all prefix read", 10'(out_valid_o), 10'h0);
    pulse(0, 1);
    for (int i = DEPTH; i < 70; i++) pull(i, "R4 tail after commit");

    fork send_frame(5, 8'h80); join_none
    pull(70, "R1 second frame");
    pull(71, "R1 second frame");
    pulse(1, 0);
    check(cur_word() == sent_q[70], "R7 new rewind point", cur_word(), sent_q[70]);
    pull(70, "R7 replay");
    pull(71, "R7 replay");
    pulse(1, 1);
    check(cur_word() == sent_q[72], "R6 commit wins", cur_word(), sent_q[72]);
    pulse(1, 0);
    check(cur_word() == sent_q[72], "R5 replay ignored", cur_word(), sent_q[72]);
    for (int i = 72; i < 75; i++) pull(i, "R5 continue");
    repeat (3) @(negedge clk_i);
    check(!out_valid_o, "R1 drained", 10'(out_valid_o), 10'h0);

    sent_q.delete();
    fork
      drive_random();
      monitor_random();
    join
    repeat (5) @(negedge clk_i);
    check(!out_valid_o && sent_q.size() == 571, "R4 all frames through", 10'(sent_q.size()), 10'(571));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule